// File: doc/BRIEF.md
# Fixed-Priority Interrupt Arbiter for a Motor-Control Timer

This block gathers single-cycle event pulses from a motor-control timer and turns them into one interrupt request for a CPU. There are eight maskable sources. Each one has a pending flag and an enable bit. The arbiter presents the most urgent source that is both pending and enabled, together with its vector index. The CPU clears a flag by returning that same vector with an acknowledge strobe.

A separate non-maskable request is taken from the rising edge of an external pin. It is latched and driven on its own output, outside the maskable scheme. It stays up until the CPU acknowledges it on a dedicated strobe.

A pending flag holds only one outstanding request. If a source fires again before it is serviced, the second event merges into the first and is lost. No error is signalled when this happens.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset, irq_o, nmi_o and vec_o are all 0 and no maskable flag is pending.
- R2: A high bit i of evt_i in a clock cycle sets pending flag i. The bit index is the vector and the priority, with 0 the most urgent: 0 preload transfer, 1 PWM counter zero, 2 compare 0, 3 tacho capture, 4 compare U, 5 compare V, 6 compare W, 7 tacho overflow.
- R3: irq_o is registered. It is high, with vec_o equal to the lowest index that is both pending and enabled, from the second rising edge after the event is sampled. When no source qualifies, irq_o is 0 and vec_o is 0.
- R4: A low en_i bit hides its source from arbitration but does not stop its flag from being set. Raising the enable later presents the source that was held.
- R5: ack_i with ack_vec_i = v clears flag v. Acknowledging a vector whose flag is not set changes nothing.
- R6: An event on a source whose flag is already set is lost. A single acknowledge clears the source.
- R7: An event and an acknowledge for the same source in the same cycle leave that flag set.
- R8: A rising edge on nmi_pin_i sets nmi_o on that clock edge, whatever the enables are. A pin held high without a new edge does not set it again.
- R9: nmi_ack_i clears nmi_o. A pin rising edge in the same cycle as nmi_ack_i keeps nmi_o set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | One-cycle event pulses, one bit per source |
| en_i | input | 8 | Per-source enable bits |
| ack_i | input | 1 | Maskable acknowledge strobe |
| ack_vec_i | input | 3 | Vector of the source being acknowledged |
| nmi_pin_i | input | 1 | External pin for the non-maskable request |
| nmi_ack_i | input | 1 | Non-maskable acknowledge strobe |
| irq_o | output | 1 | Maskable request to the CPU |
| vec_o | output | 3 | Vector of the presented request |
| nmi_o | output | 1 | Latched non-maskable request |

## Verification
Two functions can fall in the same cycle:
- A new event on a source can arrive while that source's acknowledge is being taken.
- A new rising edge on the external pin can arrive while the non-maskable acknowledge is being taken.

The bench provokes the first by pulsing a source in the exact cycle its vector is acknowledged. It provokes the second by raising the pin in the same cycle as the non-maskable acknowledge. Each case is judged correct only if the request is still presented afterwards. A further step then checks that one more acknowledge clears it. Around these cases, the bench sweeps all 256 pending patterns under several enable masks. It drains each pattern in the priority order that it computes itself.

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N  = 8,
  parameter int VW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_i,
  input  logic [N-1:0]  en_i,
  input  logic          ack_i,
  input  logic [VW-1:0] ack_vec_i,
  input  logic          nmi_pin_i,
  input  logic          nmi_ack_i,
  output logic          irq_o,
  output logic [VW-1:0] vec_o,
  output logic          nmi_o
);

  logic [N-1:0]  pend_q, ack_hit, cand;
  logic          win_any;
  logic [VW-1:0] win_v;
  logic          nmi_d_q, nmi_q;
  wire           nmi_edge = nmi_pin_i & ~nmi_d_q;

  always_comb begin
    ack_hit = '0;
    for (int i = 0; i < N; i++)
      if (ack_i && ack_vec_i == VW'(i)) ack_hit[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack_hit) | evt_i;

  assign cand = pend_q & en_i;

  always_comb begin
    win_any = 1'b0;
    win_v   = '0;
    for (int i = N - 1; i >= 0; i--)
      if (cand[i]) begin
        win_any = 1'b1;
        win_v   = VW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else begin
      irq_o <= win_any;
      vec_o <= win_v;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      nmi_d_q <= 1'b0;
      nmi_q   <= 1'b0;
    end else begin
      nmi_d_q <= nmi_pin_i;
      nmi_q   <= nmi_edge | (nmi_q & ~nmi_ack_i);
    end

  assign nmi_o = nmi_q;

endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk #(
  parameter int N  = 8,
  parameter int VW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  evt_i,
  input logic [N-1:0]  en_i,
  input logic          ack_i,
  input logic [VW-1:0] ack_vec_i,
  input logic          nmi_pin_i,
  input logic          nmi_ack_i,
  input logic          irq_o,
  input logic [VW-1:0] vec_o,
  input logic          nmi_o,
  input logic [N-1:0]  pend_q
);

  logic [N-1:0] cand_prev;
  logic [N-1:0] low_mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cand_prev <= '0;
    else        cand_prev <= pend_q & en_i;

  assign low_mask = (N'(1) << vec_o) - N'(1);

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  // R3
  winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cand_prev[vec_o] && ((cand_prev & low_mask) == '0)));

  // R3
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_o == '0 && cand_prev == '0));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !evt_i[ack_vec_i]) |=> !pend_q[$past(ack_vec_i)]);

  // R7
  ack_evt_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && evt_i[ack_vec_i]) |=> pend_q[$past(ack_vec_i)]);

  // R8
  nmi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> nmi_pin_i);

  // R9
  nmi_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack_i && !nmi_pin_i) |=> !nmi_o);

endmodule

bind irq_prio_arb irq_prio_arb_chk #(.N(N), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_i(en_i), .ack_i(ack_i),
  .ack_vec_i(ack_vec_i), .nmi_pin_i(nmi_pin_i), .nmi_ack_i(nmi_ack_i),
  .irq_o(irq_o), .vec_o(vec_o), .nmi_o(nmi_o), .pend_q(pend_q)
);

// File: tb/irq_prio_arb_tb.sv
module irq_prio_arb_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic [7:0] en_i = '0;
  logic       ack_i = 1'b0;
  logic [2:0] ack_vec_i = '0;
  logic       nmi_pin_i = 1'b0;
  logic       nmi_ack_i = 1'b0;
  logic       irq_o;
  logic [2:0] vec_o;
  logic       nmi_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_prio_arb u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_i(en_i), .ack_i(ack_i),
    .ack_vec_i(ack_vec_i), .nmi_pin_i(nmi_pin_i), .nmi_ack_i(nmi_ack_i),
    .irq_o(irq_o), .vec_o(vec_o), .nmi_o(nmi_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest(input logic [7:0] b);
    for (int i = 0; i < 8; i++) if (b[i]) return i;
    return -1;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] p);
    evt_i = p; tick(); evt_i = '0; tick();
  endtask

  task automatic ack(input int v);
    ack_i = 1'b1; ack_vec_i = 3'(v); tick(); ack_i = 1'b0; tick();
  endtask

  task automatic expect_req(input string req, input logic [7:0] cand);
    int w;
    w = lowest(cand);
    chk(req, int'(irq_o), (w >= 0) ? 1 : 0);
    chk(req, int'(vec_o), (w >= 0) ? w : 0);
  endtask

  task automatic clear_all();
    for (int v = 0; v < 8; v++) ack(v);
  endtask

  initial begin
    logic [7:0] masks [4];
    masks[0] = 8'hFF; masks[1] = 8'h55; masks[2] = 8'hF0; masks[3] = 8'h00;
    tick(); tick();
    // R1: reset state
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 vec", int'(vec_o), 0);
    chk("R1 nmi", int'(nmi_o), 0);
    rst_n = 1'b1;
    tick(); tick();
    en_i = 8'hFF; tick(); tick();
    // R1: nothing pending after reset
    chk("R1 idle", int'(irq_o), 0);

    // R2 R3 R4 R5: sweep all pending patterns under several masks
    for (int mi = 0; mi < 4; mi++) begin
      for (int p = 0; p < 256; p++) begin
        logic [7:0] left;
        en_i = masks[mi];
        pulse(8'(p));
        left = 8'(p);
        while ((left & masks[mi]) != 0) begin
          int w;
          expect_req("R3 drain", left & masks[mi]);
          w = lowest(left & masks[mi]);
          ack(w);
          left[w] = 1'b0;
        end
        expect_req("R5 drained", 8'h00);
        en_i = 8'hFF; tick(); tick();
        expect_req("R4 held", left);
        clear_all();
        expect_req("R5 cleared", 8'h00);
      end
    end

    // R5: acknowledge of a non-pending vector has no effect
    pulse(8'b0010_0000);
    ack(2);
    expect_req("R5 stray ack", 8'b0010_0000);
    ack(5);
    expect_req("R5 ack", 8'h00);

    // R6: repeated event while pending is lost
    pulse(8'b0000_1000);
    pulse(8'b0000_1000);
    expect_req("R6 pending", 8'b0000_1000);
    ack(3);
    expect_req("R6 single ack", 8'h00);

    // R7: event and acknowledge of the same source in one cycle
    pulse(8'b0000_0100);
    evt_i = 8'b0000_0100; ack_i = 1'b1; ack_vec_i = 3'd2; tick();
    evt_i = '0; ack_i = 1'b0; tick();
    expect_req("R7 coincide", 8'b0000_0100);
    ack(2);
    expect_req("R7 after", 8'h00);

    // R8: NMI edge, independent of enables
    en_i = 8'h00;
    nmi_pin_i = 1'b1; tick();
    chk("R8 nmi set", int'(nmi_o), 1);
    chk("R8 irq untouched", int'(irq_o), 0);
    nmi_ack_i = 1'b1; tick(); nmi_ack_i = 1'b0; tick();
    // R9: ack clears, level alone does not re-set (R8)
    chk("R9 nmi ack", int'(nmi_o), 0);
    tick();
    chk("R8 level no reset", int'(nmi_o), 0);
    nmi_pin_i = 1'b0; tick();
    // R9: edge in same cycle as ack wins
    nmi_pin_i = 1'b1; nmi_ack_i = 1'b1; tick(); nmi_ack_i = 1'b0; tick();
    chk("R9 edge vs ack", int'(nmi_o), 1);
    nmi_ack_i = 1'b1; tick(); nmi_ack_i = 1'b0; tick();
    chk("R9 final ack", int'(nmi_o), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule